// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit pipeline front end and works out, every clock, the address of the next instruction to fetch. The fetched instruction word and a single flag that reports whether the two register source operands are equal feed it. From these it selects among straight-line flow, two conditional branches (equal and not-equal) and an unconditional region-local jump.

The counter register is inside the block and is cleared by a synchronous active-low reset. The current counter is driven out for the fetch stage. A combinational flag reports, in the same cycle as the instruction is presented, whether that instruction redirects the flow. Fetch memory, hazard detection, delay slots and jumps through a register belong to neighbouring blocks.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter loads address 0 at that edge.
- R2: An instruction whose opcode (bits 31:26) is not 2, 4 or 5, or a conditional branch that is not taken, advances the counter by 4 modulo 2^32 at the next edge.
- R3: Opcode 4 is the branch-if-equal; it is taken exactly when `ops_equal` is 1.
- R4: Opcode 5 is the branch-if-not-equal; it is taken exactly when `ops_equal` is 0.
- R5: A taken branch loads counter + 4 + (bits 15:0 sign-extended and multiplied by 4), modulo 2^32, so negative offsets move backwards and the sum wraps through address 0.
- R6: Opcode 2 is the jump; it loads {counter bits 31:28, instruction bits 25:0, 2'b00} whatever the value of `ops_equal`. For example, field 0x0100008 from counter 0x00000020 gives 0x00400020.
- R7: `taken` is 1 in the same cycle exactly when the presented instruction is a jump or a taken branch, and 0 otherwise.
- R8: Bits 1:0 of `pc_out` are always 0.
- R9: A taken branch-if-equal with offset 1 skips exactly one instruction: the counter moves from P to P + 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word fetched at `pc_out` |
| ops_equal | input | 1 | 1 when the two register source operands are equal |
| pc_out | output | 32 | Current program counter |
| taken | output | 1 | Presented instruction redirects the flow |

## Verification
The assertions assume that `instr` and `ops_equal` are settled before each rising edge and that they describe the instruction at the current counter. They also assume that reset is held for at least one edge from time zero. The bench drives both inputs only in the low phase of the clock and holds `rst_n` low from the start. Each instruction word is built from a chosen opcode and field, so every case the assertions rely on is a well-defined word. Offsets at both ends of the signed range, a wrap through address 0 and a jump out of the top address region are included deliberately.

// File: rtl/npc_pkg.sv
// Package: shared opcode values and the control-flow class used between
// the decoder and the selector of the next program counter unit.
package npc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

    // Class of control flow an instruction word asks for.
    typedef enum logic [1:0] {
        CF_SEQ = 2'd0,
        CF_BEQ = 2'd1,
        CF_BNE = 2'd2,
        CF_JMP = 2'd3
    } cf_kind_t;

endpackage

// File: rtl/npc_decode.sv
// Module: npc_decode
// Splits an instruction word into its control-flow class, its 16-bit
// branch offset field and its jump address field.
// Assumes the opcode sits in the top OPC_W bits and that the jump field
// and the opcode together cover the whole word.
module npc_decode
    import npc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [XLEN-1:0]  instr,
    output cf_kind_t         kind,
    output logic [IMM_W-1:0] imm,
    output logic [JF_W-1:0]  jfield
);

    logic [OPC_W-1:0] opcode;

    assign opcode = instr[XLEN-1 -: OPC_W];
    assign imm    = instr[IMM_W-1:0];
    assign jfield = instr[JF_W-1:0];

    // Map the opcode onto a control-flow class.
    always_comb begin
        unique case (opcode)
            OPC_JUMP: kind = CF_JMP;
            OPC_BEQ:  kind = CF_BEQ;
            OPC_BNE:  kind = CF_BNE;
            default:  kind = CF_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module: npc_target
// Forms the three candidate addresses in parallel: the fall-through
// address, the PC-relative branch target and the region-local jump target.
// Assumes word-scaled fields (shift by two) and XLEN > JF_W + 2.
module npc_target #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16,
    parameter int JF_W  = 26
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [JF_W-1:0]  jfield,
    output logic [XLEN-1:0]  seq_tgt,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);

    localparam int SHIFT  = 2;
    localparam int HI_W   = XLEN - JF_W - SHIFT;
    localparam int EXT_W  = XLEN - IMM_W;
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(1) << SHIFT;

    logic [XLEN-1:0] imm_ext;

    // Sign-extend the branch offset to the full address width.
    always_comb imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Fall-through address, which also serves as the branch base.
    always_comb seq_tgt = pc + WORD_BYTES;

    // Word-scaled branch displacement added to the fall-through address.
    always_comb br_tgt = seq_tgt + (imm_ext << SHIFT);

    // Keep the current region bits, replace the rest with the scaled field.
    always_comb jmp_tgt = {pc[XLEN-1 -: HI_W], jfield, {SHIFT{1'b0}}};

endmodule

// File: rtl/npc_select.sv
// Module: npc_select
// Chooses the next address among the candidates from the control-flow
// class and the operand comparison, and flags a redirect.
// Assumes the candidates are already formed for the current counter.
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cf_kind_t        kind,
    input  logic            ops_equal,
    input  logic [XLEN-1:0] seq_tgt,
    input  logic [XLEN-1:0] br_tgt,
    input  logic [XLEN-1:0] jmp_tgt,
    output logic [XLEN-1:0] next_pc,
    output logic            redirect
);

    // Resolve the branch condition and pick the matching candidate.
    always_comb begin
        redirect = 1'b0;
        next_pc  = seq_tgt;
        unique case (kind)
            CF_JMP: begin
                redirect = 1'b1;
                next_pc  = jmp_tgt;
            end
            CF_BEQ: begin
                redirect = ops_equal;
                next_pc  = ops_equal ? br_tgt : seq_tgt;
            end
            CF_BNE: begin
                redirect = !ops_equal;
                next_pc  = ops_equal ? seq_tgt : br_tgt;
            end
            default: begin
                redirect = 1'b0;
                next_pc  = seq_tgt;
            end
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Holds the program counter and advances it each clock to the fall-through
// address, a taken conditional branch target or a jump target.
// Assumes instr and ops_equal describe the instruction at pc_out and are
// stable before the rising edge; reset is synchronous and active low.
module npc_unit
    import npc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              IMM_W    = 16,
    parameter int              JF_W     = 26,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] instr,
    input  logic            ops_equal,
    output logic [XLEN-1:0] pc_out,
    output logic            taken
);

    cf_kind_t         kind;
    logic [IMM_W-1:0] imm;
    logic [JF_W-1:0]  jfield;
    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  seq_tgt;
    logic [XLEN-1:0]  br_tgt;
    logic [XLEN-1:0]  jmp_tgt;
    logic [XLEN-1:0]  next_pc;

    npc_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .JF_W(JF_W)) u_decode (
        .instr  (instr),
        .kind   (kind),
        .imm    (imm),
        .jfield (jfield)
    );

    npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JF_W(JF_W)) u_target (
        .pc      (pc_q),
        .imm     (imm),
        .jfield  (jfield),
        .seq_tgt (seq_tgt),
        .br_tgt  (br_tgt),
        .jmp_tgt (jmp_tgt)
    );

    npc_select #(.XLEN(XLEN)) u_select (
        .kind      (kind),
        .ops_equal (ops_equal),
        .seq_tgt   (seq_tgt),
        .br_tgt    (br_tgt),
        .jmp_tgt   (jmp_tgt),
        .next_pc   (next_pc),
        .redirect  (taken)
    );

    // Program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end

    assign pc_out = pc_q;

endmodule

// File: rtl/npc_unit_chk.sv
// Module: npc_unit_chk
// Property checker for npc_unit, attached by bind. Observes only the
// ports of the top module.
module npc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] instr,
    input logic            ops_equal,
    input logic [XLEN-1:0] pc_out,
    input logic            taken
);

    logic [5:0]      op;
    logic [XLEN-1:0] disp;
    logic            is_jmp;
    logic            is_beq;
    logic            is_bne;

    assign op     = instr[XLEN-1 -: 6];
    assign disp   = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
    assign is_jmp = (op == 6'd2);
    assign is_beq = (op == 6'd4);
    assign is_bne = (op == 6'd5);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> pc_out == '0);

    assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> pc_out == $past(pc_out) + XLEN'(4));

    assert_beq_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_beq && ops_equal) |=> pc_out == $past(pc_out) + XLEN'(4) + $past(disp));

    assert_bne_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bne && !ops_equal) |=> pc_out == $past(pc_out) + XLEN'(4) + $past(disp));

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_jmp |=> pc_out == {$past(pc_out[XLEN-1 -: XLEN-28]), $past(instr[25:0]), 2'b00});

    assert_taken_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken == (is_jmp || (is_beq && ops_equal) || (is_bne && !ops_equal)));

    assert_word_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .ops_equal (ops_equal),
    .pc_out    (pc_out),
    .taken     (taken)
);

// File: tb/npc_unit_bench.sv
// Bench for npc_unit: a behavioural address model is stepped alongside the
// design and compared with pc_out and taken on every clock.
module npc_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'd0;
    logic        ops_equal = 1'b0;
    logic [31:0] pc_out;
    logic        taken;

    int          n_checks = 0;
    int          n_fails = 0;
    logic [31:0] model_pc = 32'd0;
    bit          finished = 1'b0;

    npc_unit u_npc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .ops_equal (ops_equal),
        .pc_out    (pc_out),
        .taken     (taken)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_i(input int opc, input logic [15:0] off);
        return {6'(opc), 10'd0, off};
    endfunction

    function automatic logic [31:0] mk_j(input logic [25:0] fld);
        return {6'd2, fld};
    endfunction

    // Present one instruction in the low phase, compare, then step the model.
    task automatic step(input logic [31:0] ins, input logic eq, input string req);
        int          opc;
        logic        exp_taken;
        logic [31:0] exp_next;
        logic [31:0] off;
        opc = int'(ins[31:26]);
        off = 32'($signed(ins[15:0])) * 32'd4;
        instr     = ins;
        ops_equal = eq;
        case (opc)
            2: begin exp_taken = 1'b1; exp_next = {model_pc[31:28], ins[25:0], 2'b00}; end
            4: begin exp_taken = eq;   exp_next = eq ? model_pc + 32'd4 + off : model_pc + 32'd4; end
            5: begin exp_taken = !eq;  exp_next = eq ? model_pc + 32'd4 : model_pc + 32'd4 + off; end
            default: begin exp_taken = 1'b0; exp_next = model_pc + 32'd4; end
        endcase
        #1;
        check32({req, " pc"}, pc_out, model_pc);
        check32({req, " R7 taken"}, {31'd0, taken}, {31'd0, exp_taken});
        check32("R8 alignment", {30'd0, pc_out[1:0]}, 32'd0);
        @(posedge clk);
        model_pc = exp_next;
        @(negedge clk);
    endtask

    // Hold reset across one edge with a jump presented, then release.
    task automatic reset_cycle();
        rst_n = 1'b0;
        instr = mk_j(26'h3ff_ffff);
        ops_equal = 1'b1;
        @(posedge clk);
        model_pc = 32'd0;
        @(negedge clk);
        #1;
        check32("R1 reset", pc_out, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check32("R1 reset", pc_out, 32'd0);
        rst_n = 1'b1;

        step(mk_i(0, 16'h0000), 1'b1, "R2 plain");           // 0 -> 4
        step(mk_i(8, 16'h0010), 1'b0, "R2 other opcode");    // 4 -> 8
        step(mk_i(4, 16'h0005), 1'b0, "R3 beq not taken");   // 8 -> 12
        step(mk_i(4, 16'h0001), 1'b1, "R9 beq skip one");    // 12 -> 20
        step(mk_i(5, 16'h0003), 1'b1, "R4 bne not taken");   // 20 -> 24
        step(mk_i(5, 16'h0003), 1'b0, "R4 bne taken");       // 24 -> 40
        step(mk_i(4, 16'hfffd), 1'b1, "R5 backward");        // 40 -> 32
        step(mk_j(26'h010_0008), 1'b0, "R6 jump");           // 32 -> 0x00400020
        step(mk_i(3, 16'h0000), 1'b1, "R2 opcode 3");        // -> 0x00400024
        step(mk_j(26'h000_0000), 1'b1, "R6 jump eq ignored");// -> 0
        step(mk_i(4, 16'hfffe), 1'b1, "R5 wrap below zero"); // 0 -> 0xfffffffc
        step(mk_j(26'h000_0003), 1'b0, "R6 region kept");    // -> 0xf000000c
        step(mk_i(5, 16'h7fff), 1'b0, "R5 max forward");     // -> 0xf002000c
        step(mk_i(4, 16'h8000), 1'b1, "R5 max backward");    // -> 0xf0000010
        step(mk_i(6, 16'h0000), 1'b1, "R2 opcode 6");        // -> 0xf0000014
        reset_cycle();
        step(mk_i(4, 16'hffff), 1'b1, "R5 self loop");       // 0 -> 0
        step(mk_i(4, 16'hfffe), 1'b1, "R5 wrap again");      // 0 -> 0xfffffffc
        step(mk_i(0, 16'h0000), 1'b0, "R2 wrap to zero");    // -> 0

        for (int k = 0; k < 300; k++) begin
            int          sel;
            logic [31:0] w;
            sel = int'($urandom_range(0, 4));
            w   = $urandom;
            case (sel)
                0: w[31:26] = 6'd2;
                1: w[31:26] = 6'd4;
                2: w[31:26] = 6'd5;
                3: w[31:26] = 6'd0;
                default: w[31:26] = 6'($urandom_range(6, 63));
            endcase
            step(w, 1'($urandom_range(0, 1)), "R2 R3 R4 R5 R6 mixed");
        end
        #1;
        check32("R2 final pc", pc_out, model_pc);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule